// File: doc/BRIEF.md
# Phase-Frequency Detector Charge-Pump Controller

This block compares a divided reference clock with a divided feedback clock and produces the two switch controls of a three-state charge pump: UP, which makes the pump source current, and DOWN, which makes it sink current. When neither control is high the pump output floats. Both divided clocks are asynchronous to the fast system clock that runs the block. Each one passes through a two-flop synchronizer, and its rising edge is found in logic.

A three-state machine holds the pump condition. The states are SINK, TRI (high impedance) and SRC. A reference rising edge moves the machine one step toward SRC, and a feedback rising edge moves it one step toward SINK. The machine saturates at both ends. Falling edges have no effect, and a reference edge and a feedback edge found in the same cycle cancel. When the reference leads by a fixed delay at equal frequency, UP is high for that delay once in every period. A feedback lead gives the mirror result on DOWN.

A programmable minimum pulse removes the dead zone. Every detected rising edge forces both controls high for a number of system-clock cycles. So even with zero phase error the pump receives short, balanced correction pulses.

Top module: `pfd_cp_ctrl`

## Requirements
- R1: A synchronous reset (`rst_i` high at a clock edge) puts the machine in TRI, clears the minimum-pulse counter and clears the synchronizer history. After reset `up_o` and `dn_o` are both 0. An input that is already high when reset ends is then seen as a rising edge.
- R2: A reference rising edge with no feedback rising edge in the same cycle makes these transitions: SINK_TO_TRI and TRI_TO_SRC.
- R3: A reference-only rising edge in SRC leaves the machine in SRC (SRC_HOLD).
- R4: A feedback rising edge with no reference rising edge in the same cycle makes these transitions: SRC_TO_TRI and TRI_TO_SINK.
- R5: A feedback-only rising edge in SINK leaves the machine in SINK (SINK_HOLD).
- R6: Falling edges and steady levels on either input leave the state unchanged.
- R7: When both rising edges are detected in the same cycle, the state is unchanged.
- R8: With no minimum pulse running, `up_o` is 1 only in SRC, `dn_o` is 1 only in SINK, and both are 0 in TRI.
- R9: Each detected rising edge loads `min_on_i` into the minimum-pulse counter. While the counter is nonzero, both `up_o` and `dn_o` are 1, for exactly `min_on_i` cycles. A value of 0 disables the pulse.
- R10: An input change sampled at clock edge k first changes the outputs just after edge k+2. That is, the outputs are still unchanged after edge k+1.
- R11: At equal input periods with the reference leading by tau system cycles and `min_on_i` = 0, `up_o` is high for exactly tau cycles per period and `dn_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast system clock |
| rst_i | input | 1 | Synchronous reset, active high |
| ref_div_i | input | 1 | Divided reference clock, asynchronous |
| fb_div_i | input | 1 | Divided feedback clock, asynchronous |
| min_on_i | input | MIN_W | Minimum pulse length in system cycles; 0 disables it |
| up_o | output | 1 | Charge-pump source control |
| dn_o | output | 1 | Charge-pump sink control |

## Verification
The hardest condition to reach is a reference rising edge and a feedback rising edge resolving in the same system cycle, since the two inputs are asynchronous. The condition matters most while a minimum pulse from an earlier edge is still running. The random stimulus sometimes toggles both inputs at the same moment, which drives this coincidence directly through the synchronizers. It also changes `min_on_i` now and then, so that pulses reload on top of pulses. Directed cases then fix the zero-phase-error case and the constant-lead case, where the exact pulse widths are known.

// File: rtl/pfd_cp_pkg.sv
package pfd_cp_pkg;
    typedef enum logic [1:0] {
        CP_SINK = 2'd0,
        CP_TRI  = 2'd1,
        CP_SRC  = 2'd2
    } cp_state_e;
endpackage

// File: rtl/pfd_edge_sync.sv
module pfd_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic d_i,
    output logic rise_o
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] chain_q;
    logic          hist_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            chain_q <= '0;
            hist_q  <= 1'b0;
        end else begin
            chain_q <= {chain_q[LAST-1:0], d_i};
            hist_q  <= chain_q[LAST];
        end
    end

    assign rise_o = chain_q[LAST] & ~hist_q;
endmodule

// File: rtl/pfd_cp_fsm.sv
module pfd_cp_fsm
    import pfd_cp_pkg::*;
(
    input  logic      clk_i,
    input  logic      rst_i,
    input  logic      ref_rise_i,
    input  logic      fb_rise_i,
    output cp_state_e state_o,
    output logic      src_o,
    output logic      snk_o
);
    cp_state_e state_q, state_d;

    always_ff @(posedge clk_i) begin
        if (rst_i) state_q <= CP_TRI;
        else       state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (ref_rise_i && !fb_rise_i) begin
            unique case (state_q)
                CP_SINK: state_d = CP_TRI;
                CP_TRI:  state_d = CP_SRC;
                CP_SRC:  state_d = CP_SRC;
                default: state_d = CP_TRI;
            endcase
        end else if (fb_rise_i && !ref_rise_i) begin
            unique case (state_q)
                CP_SRC:  state_d = CP_TRI;
                CP_TRI:  state_d = CP_SINK;
                CP_SINK: state_d = CP_SINK;
                default: state_d = CP_TRI;
            endcase
        end
    end

    always_comb begin
        src_o = 1'b0;
        snk_o = 1'b0;
        unique case (state_q)
            CP_SRC:  src_o = 1'b1;
            CP_SINK: snk_o = 1'b1;
            CP_TRI:  ;
            default: ;
        endcase
    end

    assign state_o = state_q;
endmodule

// File: rtl/pfd_min_pulse.sv
module pfd_min_pulse #(
    parameter int MIN_W = 4
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             trig_i,
    input  logic [MIN_W-1:0] len_i,
    output logic             active_o
);
    logic [MIN_W-1:0] cnt_q;

    always_ff @(posedge clk_i) begin
        if (rst_i)              cnt_q <= '0;
        else if (trig_i)        cnt_q <= len_i;
        else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end

    assign active_o = (cnt_q != '0);
endmodule

// File: rtl/pfd_cp_ctrl.sv
module pfd_cp_ctrl
    import pfd_cp_pkg::*;
#(
    parameter int MIN_W       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             ref_div_i,
    input  logic             fb_div_i,
    input  logic [MIN_W-1:0] min_on_i,
    output logic             up_o,
    output logic             dn_o
);
    localparam int N_IN = 2;

    logic [N_IN-1:0] raw_in;
    logic [N_IN-1:0] rise;
    logic            ref_rise;
    logic            fb_rise;
    cp_state_e       state;
    logic            st_src;
    logic            st_snk;
    logic            pulse_act;

    assign raw_in = {fb_div_i, ref_div_i};

    for (genvar i = 0; i < N_IN; i++) begin : g_in
        pfd_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk_i  (clk_i),
            .rst_i  (rst_i),
            .d_i    (raw_in[i]),
            .rise_o (rise[i])
        );
    end

    assign ref_rise = rise[0];
    assign fb_rise  = rise[1];

    pfd_cp_fsm u_fsm (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .ref_rise_i (ref_rise),
        .fb_rise_i  (fb_rise),
        .state_o    (state),
        .src_o      (st_src),
        .snk_o      (st_snk)
    );

    pfd_min_pulse #(.MIN_W(MIN_W)) u_pulse (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .trig_i   (ref_rise | fb_rise),
        .len_i    (min_on_i),
        .active_o (pulse_act)
    );

    assign up_o = st_src | pulse_act;
    assign dn_o = st_snk | pulse_act;
endmodule

// File: rtl/pfd_cp_ctrl_chk.sv
module pfd_cp_ctrl_chk
    import pfd_cp_pkg::*;
#(
    parameter int MIN_W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             ref_rise,
    input logic             fb_rise,
    input cp_state_e        state,
    input logic             pulse_act,
    input logic [MIN_W-1:0] min_on,
    input logic             up,
    input logic             dn
);
    p_reset_tri_r1: assert property (@(posedge clk)
        rst |=> (state == CP_TRI) && !up && !dn);

    p_step_up_r2: assert property (@(posedge clk) disable iff (rst)
        (ref_rise && !fb_rise && state == CP_TRI) |=> state == CP_SRC);

    p_sink_up_r2: assert property (@(posedge clk) disable iff (rst)
        (ref_rise && !fb_rise && state == CP_SINK) |=> state == CP_TRI);

    p_src_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (ref_rise && !fb_rise && state == CP_SRC) |=> state == CP_SRC);

    p_step_dn_r4: assert property (@(posedge clk) disable iff (rst)
        (fb_rise && !ref_rise && state == CP_TRI) |=> state == CP_SINK);

    p_src_dn_r4: assert property (@(posedge clk) disable iff (rst)
        (fb_rise && !ref_rise && state == CP_SRC) |=> state == CP_TRI);

    p_sink_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (fb_rise && !ref_rise && state == CP_SINK) |=> state == CP_SINK);

    p_no_edge_r6: assert property (@(posedge clk) disable iff (rst)
        (!ref_rise && !fb_rise) |=> $stable(state));

    p_both_edges_r7: assert property (@(posedge clk) disable iff (rst)
        (ref_rise && fb_rise) |=> $stable(state));

    p_tri_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        (state == CP_TRI && !pulse_act) |-> (!up && !dn));

    p_pulse_both_r9: assert property (@(posedge clk) disable iff (rst)
        ((ref_rise || fb_rise) && min_on != '0) |=> (up && dn));

    p_pulse_off_r9: assert property (@(posedge clk) disable iff (rst)
        ((ref_rise || fb_rise) && min_on == '0) |=> !pulse_act);
endmodule

bind pfd_cp_ctrl pfd_cp_ctrl_chk #(.MIN_W(MIN_W)) u_chk (
    .clk       (clk_i),
    .rst       (rst_i),
    .ref_rise  (ref_rise),
    .fb_rise   (fb_rise),
    .state     (state),
    .pulse_act (pulse_act),
    .min_on    (min_on_i),
    .up        (up_o),
    .dn        (dn_o)
);

// File: tb/pfd_cp_ctrl_tb.sv
module pfd_cp_ctrl_tb_top;
    localparam int MIN_W = 4;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             ref_in = 1'b0;
    logic             fb_in = 1'b0;
    logic [MIN_W-1:0] min_on = '0;
    logic             up, dn;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    pfd_cp_ctrl #(.MIN_W(MIN_W)) dut_i (
        .clk_i     (clk),
        .rst_i     (rst),
        .ref_div_i (ref_in),
        .fb_div_i  (fb_in),
        .min_on_i  (min_on),
        .up_o      (up),
        .dn_o      (dn)
    );

    // Reference model built from the requirements: 0 sink, 1 tri, 2 source
    logic       mr1, mr2, mr3, mf1, mf2, mf3;
    int         ms, mc;

    function automatic int step_state(int s, bit r, bit f);
        if (r && !f) return (s < 2) ? s + 1 : 2;
        if (f && !r) return (s > 0) ? s - 1 : 0;
        return s;
    endfunction

    function automatic bit exp_up(int s, int c);
        return (s == 2) || (c != 0);
    endfunction

    function automatic bit exp_dn(int s, int c);
        return (s == 0) || (c != 0);
    endfunction

    always @(posedge clk) begin
        bit rr, fr;
        if (rst) begin
            {mr1, mr2, mr3, mf1, mf2, mf3} <= '0;
            ms <= 1;
            mc <= 0;
        end else begin
            rr = mr2 & ~mr3;
            fr = mf2 & ~mf3;
            mr1 <= ref_in; mr2 <= mr1; mr3 <= mr2;
            mf1 <= fb_in;  mf2 <= mf1; mf3 <= mf2;
            ms <= step_state(ms, rr, fr);
            if (rr || fr)     mc <= int'(min_on);
            else if (mc != 0) mc <= mc - 1;
        end
    end

    task automatic chk(string tag, int act, int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Continuous model comparison on every falling edge after reset
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk("model R2,R3,R4,R5,R6,R7,R8,R9 up", int'(up), int'(exp_up(ms, mc)));
            chk("model R2,R3,R4,R5,R6,R7,R8,R9 dn", int'(dn), int'(exp_dn(ms, mc)));
        end
    end

    task automatic tick(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        tick(3);
        rst = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        int cu, cd;
        void'($urandom(32'd1234));
        tick(3);
        chk("R1 reset up", int'(up), 0);
        chk("R1 reset dn", int'(dn), 0);
        rst = 1'b0;
        tick(4);

        // R10 latency and R2 TRI_TO_SRC
        ref_in = 1'b1;
        tick(2);
        chk("R10 no change after two edges", int'(up), 0);
        tick(1);
        chk("R2 TRI_TO_SRC", int'(up), 1);
        // R6 falling edge ignored, R3 SRC_HOLD
        ref_in = 1'b0; tick(5);
        chk("R6 falling edge ignored", int'(up), 1);
        ref_in = 1'b1; tick(5);
        chk("R3 SRC_HOLD", int'(up), 1);
        // R4 SRC_TO_TRI
        fb_in = 1'b1; tick(5);
        chk("R4 SRC_TO_TRI up", int'(up), 0);
        chk("R8 TRI dn low", int'(dn), 0);
        fb_in = 1'b0; tick(5);
        fb_in = 1'b1; tick(5);
        chk("R4 TRI_TO_SINK", int'(dn), 1);
        chk("R8 SINK up low", int'(up), 0);
        fb_in = 1'b0; tick(5);
        fb_in = 1'b1; tick(5);
        chk("R5 SINK_HOLD", int'(dn), 1);
        // R7 simultaneous edges from SINK
        fb_in = 1'b0; ref_in = 1'b0; tick(5);
        fb_in = 1'b1; ref_in = 1'b1; tick(5);
        chk("R7 both edges keep SINK", int'(dn), 1);
        ref_in = 1'b0; tick(5);
        ref_in = 1'b1; tick(5);
        chk("R2 SINK_TO_TRI", int'(dn), 0);

        // R9 zero phase error with minimum pulse of 3
        do_reset();
        ref_in = 1'b0; fb_in = 1'b0; min_on = 4'd3; tick(5);
        ref_in = 1'b1; fb_in = 1'b1;
        cu = 0; cd = 0;
        for (int i = 0; i < 10; i++) begin
            tick(1);
            cu += int'(up); cd += int'(dn);
        end
        chk("R9 pulse width up", cu, 3);
        chk("R9 pulse width dn", cd, 3);
        // R9 zero disables
        min_on = '0; ref_in = 1'b0; fb_in = 1'b0; tick(5);
        ref_in = 1'b1; fb_in = 1'b1;
        cu = 0; cd = 0;
        for (int i = 0; i < 10; i++) begin
            tick(1);
            cu += int'(up); cd += int'(dn);
        end
        chk("R9 zero disables up", cu, 0);
        chk("R9 zero disables dn", cd, 0);

        // R11 constant lead of 5 cycles, period 20
        do_reset();
        ref_in = 1'b0; fb_in = 1'b0; min_on = '0;
        tick(5);
        cu = 0; cd = 0;
        for (int p = 0; p < 4; p++) begin
            for (int t = 0; t < 20; t++) begin
                ref_in = (t < 10);
                fb_in  = (t >= 5 && t < 15);
                tick(1);
                if (p == 3) begin
                    cu += int'(up); cd += int'(dn);
                end
            end
        end
        chk("R11 up cycles per period", cu, 5);
        chk("R11 dn cycles per period", cd, 0);

        // Random stimulus checked against the model
        do_reset();
        for (int i = 0; i < 6000; i++) begin
            int r;
            r = int'($urandom % 16);
            if (r == 0)      begin ref_in = ~ref_in; fb_in = ~fb_in; end
            else if (r < 3)  ref_in = ~ref_in;
            else if (r < 5)  fb_in = ~fb_in;
            if (i % 150 == 0) min_on = MIN_W'($urandom % 5);
            tick(1);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule